// File: doc/BRIEF.md
# Chained Serial DAC Frame Master

This block is the host end of a serial link to a string of identical 16-bit-command DAC devices wired in a chain. Every device's data output feeds the next device's data input, and all devices share one serial clock and one active-low select/load line. The host logic hands the block one command word per device through a valid/ready port. The block gathers the whole set and sends it as a single frame of `NUM_DEV * WORD_W` bits, most significant bit first, with the select line held low for the whole frame. It then raises the select line once, so that every device in the chain latches its own word in the same instant.

The serial clock is not a separate clock domain. It is a level driven from the system clock by a phase counter. Every timing minimum of the device interface is a parameter counted in system-clock cycles:
- the lead time from select falling to the first low phase,
- the low phase, which also serves as the data setup window,
- the high phase,
- the trail time before select rises,
- the select-high gap between frames.

The word accepted k-th (k = 0 first) is meant for device k, the device nearest the host. It leaves the block last, so that after the frame it sits in device 0. A device can be kept asleep by placing its sleep command in its slot on every frame. The block forwards every word bit for bit and does not interpret any of them.

The controller is a state machine with these states:
- `S_IDLE` (waiting for a first word),
- `S_GATHER` (collecting the remaining words),
- `S_LEAD` (select low, clock low),
- `S_LOW` (clock low, current bit on the data line),
- `S_HIGH` (clock high),
- `S_TRAIL` (select still low after the last bit),
- `S_GAP` (select high pulse).

Its transitions are:
- IDLE to GATHER on a first accepted word when more words are needed, or IDLE to LEAD when only one word is needed.
- GATHER to LEAD on the last word.
- LEAD to LOW, and LOW to HIGH, when the phase timer runs out.
- HIGH to LOW when more bits remain, or HIGH to TRAIL after the last bit.
- TRAIL to GAP, and GAP to IDLE, each when its timer runs out.

Top module: `dac_chain_host`

## Requirements
- R1: After reset, `ser_sel_n` is 1, `ser_clk` is 0, `ser_dat` is 0, `busy` is 0, `done` is 0 and `in_ready` is 1.
- R2: Words are taken on cycles where `in_valid` and `in_ready` are both high. `in_ready` is high only while idle or gathering, so it is 0 for every cycle in which `ser_sel_n` is low. A word presented with `in_valid` low is not taken.
- R3: A frame carries the words unchanged, each MSB first. The word accepted last (device `NUM_DEV-1`) goes out first and the word accepted first goes out last. A sleep command (top four bits 1110) is forwarded like any other word.
- R4: `ser_sel_n` stays low for exactly `NUM_DEV*WORD_W` rising edges of `ser_clk` and then rises once.
- R5: `ser_clk` is 0 in every cycle in which `ser_sel_n` is 1. It is also 0 in the cycle before `ser_sel_n` falls and in the cycle in which it falls.
- R6: The first rising edge of `ser_clk` comes `T_LEAD + T_LOW` cycles after `ser_sel_n` falls.
- R7: Each low phase of `ser_clk` within a frame lasts `T_LOW` cycles and each high phase lasts `T_HIGH` cycles. While `ser_sel_n` is low, `ser_dat` does not change while `ser_clk` stays high, and it is stable for at least `T_LOW` cycles before each rising edge.
- R8: `ser_sel_n` rises `T_HIGH + T_TRAIL` cycles after the last rising edge of `ser_clk`.
- R9: `ser_sel_n` stays high for at least `T_GAP` cycles between frames, and no word is accepted before that gap ends.
- R10: `busy` is high from the cycle after the first word of a frame is accepted until the gap completes. `done` is then high for exactly one cycle, the first cycle with `busy` low, once per frame.
- R11: The first word of the next frame can be accepted in the same cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A command word is offered |
| in_ready | output | 1 | The block can take a word this cycle |
| in_data | input | WORD_W | Command word for the next device slot |
| ser_clk | output | 1 | Serial clock to the chain |
| ser_dat | output | 1 | Serial data to the first device |
| ser_sel_n | output | 1 | Active-low select/load shared by all devices |
| busy | output | 1 | A frame is being gathered, sent or closed |
| done | output | 1 | One-cycle pulse when a frame's gap has completed |

## Verification
The frame-completion pulse and the acceptance of the next frame's first word can fall in the same cycle, because `S_GAP` ends in `S_IDLE` with `in_ready` high while `done` is high. The bench provokes this by sending several frames back to back, so that `in_valid` is already high with the next first word when the gap ends. It then judges that `done` is high, `busy` was high one cycle earlier and is low now, and `busy` is high again the following cycle. A scoreboard fed by the driver confirms that this overlap takes the new word without losing or shifting any bit of either frame.

// File: rtl/dch_pkg.sv
package dch_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_GATHER = 3'd1,
        S_LEAD   = 3'd2,
        S_LOW    = 3'd3,
        S_HIGH   = 3'd4,
        S_TRAIL  = 3'd5,
        S_GAP    = 3'd6
    } dch_state_t;

    function automatic int max_of2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dch_timer.sv
// Down-counting phase timer: loaded with (length-1) on state entry.
module dch_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R7

endmodule

// File: rtl/dch_frame_buf.sv
// Frame store: one word register per device slot, chained into one
// long left-shifting register while the frame is being sent.
module dch_frame_buf #(
    parameter int NUM_DEV = 3,
    parameter int WORD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              shift,
    output logic              last_slot,
    output logic              msb
);

    localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic [IDX_W-1:0] idx_q;

    assign last_slot = (idx_q == IDX_W'(NUM_DEV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (wr_en) begin
            idx_q <= last_slot ? '0 : idx_q + 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_DEV; k++) begin : g_slot
        logic [WORD_W-1:0] word_q;
        logic              fill;

        if (k == 0) begin : g_head
            assign fill = 1'b0;
        end else begin : g_link
            assign fill = g_slot[k-1].word_q[WORD_W-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (shift) begin
                word_q <= {word_q[WORD_W-2:0], fill};
            end else if (wr_en && (idx_q == IDX_W'(k))) begin
                word_q <= wr_data;
            end
        end
    end

    assign msb = g_slot[NUM_DEV-1].word_q[WORD_W-1];

    AST_WR_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && shift)); // R3

    AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && last_slot) |=> (idx_q == '0)); // R2

endmodule

// File: rtl/dac_chain_host.sv
module dac_chain_host
    import dch_pkg::*;
#(
    parameter int NUM_DEV = 3,
    parameter int WORD_W  = 16,
    parameter int T_LEAD  = 3,
    parameter int T_LOW   = 2,
    parameter int T_HIGH  = 2,
    parameter int T_TRAIL = 1,
    parameter int T_GAP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              ser_clk,
    output logic              ser_dat,
    output logic              ser_sel_n,
    output logic              busy,
    output logic              done
);

    localparam int FRAME_W = NUM_DEV * WORD_W;
    localparam int BIT_W   = $clog2(FRAME_W + 1);
    localparam int T_MAX   = max_of2(max_of2(max_of2(T_LEAD, T_LOW),
                                             max_of2(T_HIGH, T_TRAIL)), T_GAP);
    localparam int TMR_W   = max_of2($clog2(T_MAX + 1), 1);

    dch_state_t       state_q, state_n;
    logic [BIT_W-1:0] bits_left_q;
    logic             accept;
    logic             last_slot;
    logic             shift;
    logic             tmr_exp;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    int               phase_len;

    assign in_ready = (state_q == S_IDLE) || (state_q == S_GATHER);
    assign accept   = in_valid && in_ready;
    assign shift    = (state_q == S_HIGH) && tmr_exp;

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_n = last_slot ? S_LEAD : S_GATHER;
            S_GATHER: if (accept && last_slot) state_n = S_LEAD;
            S_LEAD:   if (tmr_exp) state_n = S_LOW;
            S_LOW:    if (tmr_exp) state_n = S_HIGH;
            S_HIGH:   if (tmr_exp) state_n = (bits_left_q == BIT_W'(1)) ? S_TRAIL : S_LOW;
            S_TRAIL:  if (tmr_exp) state_n = S_GAP;
            S_GAP:    if (tmr_exp) state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_sel_n <= 1'b1;
            ser_clk   <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            ser_sel_n <= !((state_n == S_LEAD) || (state_n == S_LOW) ||
                           (state_n == S_HIGH) || (state_n == S_TRAIL));
            ser_clk   <= (state_n == S_HIGH);
            busy      <= (state_n != S_IDLE);
            done      <= (state_q == S_GAP) && tmr_exp;
        end
    end

    // remaining-bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_left_q <= '0;
        end else if (accept && last_slot) begin
            bits_left_q <= BIT_W'(FRAME_W);
        end else if (shift) begin
            bits_left_q <= bits_left_q - 1'b1;
        end
    end

    // phase length of the state being entered
    always_comb begin
        case (state_n)
            S_LEAD:  phase_len = T_LEAD;
            S_LOW:   phase_len = T_LOW;
            S_HIGH:  phase_len = T_HIGH;
            S_TRAIL: phase_len = T_TRAIL;
            S_GAP:   phase_len = T_GAP;
            default: phase_len = 1;
        endcase
    end

    assign tmr_load = (state_n != state_q);
    assign tmr_val  = TMR_W'(phase_len - 1);

    dch_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    dch_frame_buf #(
        .NUM_DEV (NUM_DEV),
        .WORD_W  (WORD_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_data   (in_data),
        .shift     (shift),
        .last_slot (last_slot),
        .msb       (ser_dat)
    );

    AST_CLK_LOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sel_n |-> !ser_clk); // R5

    AST_SEL_FALL_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_sel_n) |-> (!ser_clk && !$past(ser_clk))); // R5

    AST_DAT_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dat)); // R7

    AST_NO_ACCEPT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_sel_n |-> !in_ready); // R2

    AST_FRAME_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_sel_n) |-> (bits_left_q == '0)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R10

endmodule

// File: tb/dac_chain_host_tb.sv
`timescale 1ns/1ps
module dac_chain_host_tb;

    localparam int NUM_DEV = 3;
    localparam int WORD_W  = 16;
    localparam int T_LEAD  = 3;
    localparam int T_LOW   = 2;
    localparam int T_HIGH  = 2;
    localparam int T_TRAIL = 1;
    localparam int T_GAP   = 4;
    localparam int FRAME_W = NUM_DEV * WORD_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [WORD_W-1:0] in_data = '0;
    logic in_ready, ser_clk, ser_dat, ser_sel_n, busy, done;

    always #10 clk = ~clk;

    dac_chain_host #(
        .NUM_DEV (NUM_DEV), .WORD_W (WORD_W), .T_LEAD (T_LEAD), .T_LOW (T_LOW),
        .T_HIGH (T_HIGH), .T_TRAIL (T_TRAIL), .T_GAP (T_GAP)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .in_data (in_data), .ser_clk (ser_clk), .ser_dat (ser_dat),
        .ser_sel_n (ser_sel_n), .busy (busy), .done (done)
    );

    int n_chk = 0;
    int n_fail = 0;
    int frames_sent = 0;
    int frames_done = 0;
    int r11_seen = 0;
    logic [WORD_W-1:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // driver: must be entered at a falling clock edge
    task automatic send_frame(input logic [FRAME_W-1:0] f, input bit keep);
        for (int k = NUM_DEV - 1; k >= 0; k--) exp_q.push_back(f[k*WORD_W +: WORD_W]);
        frames_sent++;
        for (int k = 0; k < NUM_DEV; k++) begin
            in_valid = 1'b1;
            in_data  = f[k*WORD_W +: WORD_W];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        if (!keep) in_valid = 1'b0;
    endtask

    // monitor and scoreboard
    logic p_clk, p_sel, p_dat, p_busy, p_done;
    int since_sel, lo_run, hi_run, since_rise, gap_run, dat_run, nbits;
    bit first_rise, in_gap, seen_frame, acc_pend, rst_checked;
    logic [WORD_W-1:0] sh;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_clk = 0; p_sel = 1; p_dat = 0; p_busy = 0; p_done = 0;
            since_sel = 0; lo_run = 0; hi_run = 0; since_rise = 0; gap_run = 0;
            dat_run = 0; nbits = 0; first_rise = 0; in_gap = 0; seen_frame = 0;
            acc_pend = 0; rst_checked = 0; sh = '0;
        end else begin
            bit sel_fall, sel_rise, clk_rise, clk_fall;
            sel_fall = p_sel && !ser_sel_n;
            sel_rise = !p_sel && ser_sel_n;
            clk_rise = !p_clk && ser_clk;
            clk_fall = p_clk && !ser_clk;
            if (!rst_checked) begin
                rst_checked = 1;
                chk(ser_sel_n == 1'b1, "R1 sel_n", ser_sel_n, 1);
                chk(ser_clk == 1'b0, "R1 clk", ser_clk, 0);
                chk(ser_dat == 1'b0, "R1 dat", ser_dat, 0);
                chk(busy == 1'b0, "R1 busy", busy, 0);
                chk(done == 1'b0, "R1 done", done, 0);
                chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
            end
            if (acc_pend) begin
                chk(busy == 1'b1, "R11 busy after overlap", busy, 1);
                if (busy) r11_seen++;
                acc_pend = 0;
            end
            if (ser_sel_n) chk(!ser_clk, "R5 clk low deselected", ser_clk, 0);
            else chk(!in_ready, "R2 ready in frame", in_ready, 0);
            if (sel_fall) begin
                chk(!p_clk && !ser_clk, "R5 clk at select fall", ser_clk, 0);
                if (seen_frame) chk(gap_run >= T_GAP, "R9 gap length", gap_run, T_GAP);
                first_rise = 1; nbits = 0;
            end
            if (clk_rise) begin
                if (first_rise) chk(since_sel == T_LEAD + T_LOW, "R6 lead", since_sel, T_LEAD + T_LOW);
                else chk(lo_run == T_LOW, "R7 low phase", lo_run, T_LOW);
                chk(dat_run >= T_LOW, "R7 setup", dat_run, T_LOW);
                first_rise = 0;
                sh = {sh[WORD_W-2:0], ser_dat};
                nbits++;
                if (nbits % WORD_W == 0) begin
                    if (exp_q.size() == 0) chk(0, "R3 unexpected word", int'(sh), -1);
                    else begin
                        logic [WORD_W-1:0] e;
                        e = exp_q.pop_front();
                        chk(sh == e, "R3 word", int'(sh), int'(e));
                    end
                end
            end
            if (p_clk && ser_clk) chk(ser_dat == p_dat, "R7 data held high", ser_dat, p_dat);
            if (clk_fall) chk(hi_run == T_HIGH, "R7 high phase", hi_run, T_HIGH);
            if (sel_rise) begin
                chk(nbits == FRAME_W, "R4 bits per frame", nbits, FRAME_W);
                chk(since_rise == T_HIGH + T_TRAIL, "R8 trail", since_rise, T_HIGH + T_TRAIL);
                in_gap = 1; seen_frame = 1;
            end else if (in_gap && busy) begin
                chk(!in_ready, "R9 no accept in gap", in_ready, 0);
            end
            if (p_done) chk(!done, "R10 done one cycle", done, 0);
            if (done) begin
                chk(!busy && p_busy, "R10 busy drop at done", busy, 0);
                in_gap = 0; frames_done++;
                if (in_valid) begin
                    chk(in_ready, "R11 ready with done", in_ready, 1);
                    acc_pend = 1;
                end
            end
            since_sel  = sel_fall ? 1 : since_sel + 1;
            lo_run     = clk_fall ? 1 : lo_run + 1;
            hi_run     = clk_rise ? 1 : hi_run + 1;
            since_rise = clk_rise ? 1 : since_rise + 1;
            gap_run    = sel_rise ? 1 : gap_run + 1;
            dat_run    = (ser_dat != p_dat) ? 1 : dat_run + 1;
            p_clk = ser_clk; p_sel = ser_sel_n; p_dat = ser_dat; p_busy = busy; p_done = done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R2: data with valid low is not taken
        in_data = 16'hDEAD;
        repeat (20) @(negedge clk);
        chk(!busy, "R2 idle without valid", busy, 0);
        chk(ser_sel_n, "R2 no frame without valid", ser_sel_n, 1);
        send_frame({16'h9ABC, 16'h5678, 16'h1234}, 0);
        repeat (300) @(negedge clk);
        send_frame({FRAME_W{1'b1}}, 0);
        repeat (5) @(negedge clk);
        // R3: sleep code 1110 in the middle slot, back-to-back frames (R11)
        send_frame({16'h0155, 16'hE000, 16'h83FF}, 1);
        send_frame({FRAME_W{1'b0}}, 1);
        send_frame({16'hAAAA, 16'h5555, 16'hE000}, 1);
        send_frame({16'h8001, 16'h7FFE, 16'hC3A5}, 0);
        while (frames_done < frames_sent) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(frames_done == frames_sent, "R10 done per frame", frames_done, frames_sent);
        chk(exp_q.size() == 0, "R3 all words sent", exp_q.size(), 0);
        chk(r11_seen > 0, "R11 overlap seen", r11_seen, 1);
        chk(ser_sel_n && !ser_clk, "R5 idle lines", ser_clk, 0);
        finish_run();
    end

endmodule